// File: doc/BRIEF.md
# Split-Word Registered Bus Transceiver

This block moves data between two bidirectional ports, called A and B, inside a synchronous design. Each direction has a storage element that can follow its input, hold a captured value, or capture on a rising edge of a per-direction strobe. Each direction also has its own output enable: active high for the path that drives B, active low for the path that drives A. The word is built from independent halves, and each half has a full set of controls. Tying the half controls together gives one wide transceiver. Driving them separately gives several narrow ones.

High impedance is modelled with a per-bit enable next to each output value instead of internal tri-states. A disabled output reads as zero on its data pins. Each direction's latch-enable and strobe are slow external levels. They pass through a two-stage synchronizer on the fast system clock. Edges are detected on the synchronized copy, and the storage elements load on system-clock edges. Output enables and the bus-conflict flag are combinational from their pins.

Top module: `ubt_xcvr`

## Requirements
- R1: Bits [18h+17:18h] of every data port belong to half h (default two halves of 18 bits), and only the controls with index h affect them.
- R2: A latch-enable level sampled at system-clock edge t takes effect at edge t+2. At every edge where the synchronized latch-enable is high, the storage loads the current input data, so the stored value follows the input one edge late.
- R3: After the synchronized latch-enable falls, the storage keeps the value loaded at the last edge where it was still high.
- R4: While the synchronized latch-enable is low and no strobe rising edge is detected, the stored value does not change, whatever the input data does.
- R5: With the synchronized latch-enable low, a strobe first sampled high at edge t (after being low at edge t-1) makes the storage load the input data present at edge t+2.
- R6: The A-to-B enable is active high. For half h, b_oe bits are all ones when ab_oe[h]=1 and all zeros otherwise, and b_out reads zero when disabled. The A-to-B storage keeps loading and holding while its output is disabled, and the stored value appears as soon as the output is enabled.
- R7: The B-to-A path follows R2 to R5 using ba_le, ba_ck and b_in. Its enable ba_oe_n is active low, and it drives a_out and a_oe the way R6 describes for the other direction.
- R8: An enabled output carries the stored value without inversion.
- R9: conflict[h] is 1 exactly when ab_oe[h]=1 and ba_oe_n[h]=0.
- R10: While rst_n is low, all stored values and synchronizers are zero. With enables inactive, all data and enable outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_oe | input | HALVES | A-to-B output enable per half, active high |
| ab_le | input | HALVES | A-to-B latch enable per half |
| ab_ck | input | HALVES | A-to-B capture strobe per half |
| ba_oe_n | input | HALVES | B-to-A output enable per half, active low |
| ba_le | input | HALVES | B-to-A latch enable per half |
| ba_ck | input | HALVES | B-to-A capture strobe per half |
| a_in | input | W | Value seen on the A pins |
| a_out | output | W | Value driven onto the A pins |
| a_oe | output | W | Per-bit drive enable for the A pins |
| b_in | input | W | Value seen on the B pins |
| b_out | output | W | Value driven onto the B pins |
| b_oe | output | W | Per-bit drive enable for the B pins |
| conflict | output | HALVES | Both directions of a half enabled at once |

## Verification
A latch-enable or strobe level sampled at edge t acts at edge t+2. The data loaded then is visible on the outputs right after that edge. Enables and the conflict flag follow their pins within the same cycle. The reference model keeps a four-deep history of each control level per half. It decides loads from the entries two and three edges old and applies the data of the current edge. Stimulus changes on the falling edge, and every output is compared on the next falling edge, once the rising edge between them has updated the design.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  // What a storage element does on the current system-clock edge.
  typedef enum logic [1:0] {
    MODE_HOLD   = 2'd0,
    MODE_FOLLOW = 2'd1,
    MODE_CLOCK  = 2'd2
  } ubt_mode_e;
endpackage

// File: rtl/ubt_sync.sv
module ubt_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  localparam int LAST = STAGES - 1;

  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= pin;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[LAST];
  end

  assign lvl  = stg_q[LAST];
  assign rise = stg_q[LAST] & ~prev_q;

  // The synchronized level rises only after the pin was high two edges earlier.
  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl[i]) |-> $past(pin[i], 2))
      else $error("synchronized level rose without an earlier pin level");
  end
endmodule

// File: rtl/ubt_store.sv
module ubt_store
  import ubt_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_q,
  input  logic         ck_rise,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  ubt_mode_e    mode;
  logic         load;
  logic [W-1:0] q_d, q_q;

  always_comb begin
    if (le_q)         mode = MODE_FOLLOW;
    else if (ck_rise) mode = MODE_CLOCK;
    else              mode = MODE_HOLD;
    load = (mode != MODE_HOLD);
    q_d  = load ? d : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (load) q_q <= q_d;
  end

  assign q = q_q;

  assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |=> (q == $past(d)))
    else $error("transparent storage did not load its input");

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_q && !ck_rise) |=> $stable(q))
    else $error("stored value changed with no load condition");

  assert_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_q && ck_rise) |=> (q == $past(d)))
    else $error("strobe edge did not capture the input");
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int HALF_W      = 18,
  parameter int HALVES      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int W          = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALVES-1:0] ab_oe,
  input  logic [HALVES-1:0] ab_le,
  input  logic [HALVES-1:0] ab_ck,
  input  logic [HALVES-1:0] ba_oe_n,
  input  logic [HALVES-1:0] ba_le,
  input  logic [HALVES-1:0] ba_ck,
  input  logic [W-1:0]      a_in,
  output logic [W-1:0]      a_out,
  output logic [W-1:0]      a_oe,
  input  logic [W-1:0]      b_in,
  output logic [W-1:0]      b_out,
  output logic [W-1:0]      b_oe,
  output logic [HALVES-1:0] conflict
);
  localparam int NCTL = 4 * HALVES;

  logic [NCTL-1:0] ctl_pin, ctl_lvl, ctl_rise;

  assign ctl_pin = {ba_ck, ba_le, ab_ck, ab_le};

  ubt_sync #(.N(NCTL), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ctl_pin),
    .lvl  (ctl_lvl),
    .rise (ctl_rise)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] ab_q, ba_q;
    logic              ab_en, ba_en;

    assign ab_en = ab_oe[h];
    assign ba_en = ~ba_oe_n[h];

    ubt_store #(.W(HALF_W)) u_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .le_q   (ctl_lvl[h]),
      .ck_rise(ctl_rise[HALVES + h]),
      .d      (a_in[h*HALF_W +: HALF_W]),
      .q      (ab_q)
    );

    ubt_store #(.W(HALF_W)) u_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .le_q   (ctl_lvl[2*HALVES + h]),
      .ck_rise(ctl_rise[3*HALVES + h]),
      .d      (b_in[h*HALF_W +: HALF_W]),
      .q      (ba_q)
    );

    assign b_out[h*HALF_W +: HALF_W] = ab_en ? ab_q : '0;
    assign b_oe [h*HALF_W +: HALF_W] = {HALF_W{ab_en}};
    assign a_out[h*HALF_W +: HALF_W] = ba_en ? ba_q : '0;
    assign a_oe [h*HALF_W +: HALF_W] = {HALF_W{ba_en}};
    assign conflict[h]               = ab_en & ba_en;

    assert_b_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !b_oe[h*HALF_W] |-> (b_out[h*HALF_W +: HALF_W] == '0))
      else $error("B port carries data while disabled");

    assert_a_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !a_oe[h*HALF_W] |-> (a_out[h*HALF_W +: HALF_W] == '0))
      else $error("A port carries data while disabled");

    assert_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conflict[h] == (a_oe[h*HALF_W] && b_oe[h*HALF_W]))
      else $error("conflict flag disagrees with the two enables");
  end
endmodule

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb_top;
  localparam int HW = 18;
  localparam int H  = 2;
  localparam int W  = HW * H;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [H-1:0] ab_oe, ab_le, ab_ck, ba_oe_n, ba_le, ba_ck;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
  logic [H-1:0] conflict;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  // Model state: bit k of a history is the level sampled k edges ago.
  logic [3:0]    h_able [H], h_abck [H], h_bale [H], h_back [H];
  logic [HW-1:0] m_ab [H], m_ba [H];

  always #4 clk = ~clk;

  ubt_xcvr #(.HALF_W(HW), .HALVES(H)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_ck(ab_ck),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .conflict(conflict)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string mtag(logic [3:0] le, logic [3:0] ck);
    if (le[2])              return "R2 follow";
    if (ck[2] && !ck[3])    return "R5 strobe";
    if (le[3])              return "R3 close";
    return "R4 hold";
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return W'({$urandom(), $urandom()});
  endfunction

  // One rising edge with the current inputs, then model update and compare.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    for (int h = 0; h < H; h++) begin
      string ta, tb;
      h_able[h] = {h_able[h][2:0], ab_le[h]};
      h_abck[h] = {h_abck[h][2:0], ab_ck[h]};
      h_bale[h] = {h_bale[h][2:0], ba_le[h]};
      h_back[h] = {h_back[h][2:0], ba_ck[h]};
      tb = $sformatf("R1 R8 half%0d A-to-B %s", h, mtag(h_able[h], h_abck[h]));
      ta = $sformatf("R1 R7 half%0d B-to-A %s", h, mtag(h_bale[h], h_back[h]));
      if (h_able[h][2] || (h_abck[h][2] && !h_abck[h][3])) m_ab[h] = a_in[h*HW +: HW];
      if (h_bale[h][2] || (h_back[h][2] && !h_back[h][3])) m_ba[h] = b_in[h*HW +: HW];
      chk(tb, 64'(b_out[h*HW +: HW]), ab_oe[h] ? 64'(m_ab[h]) : 64'd0);
      chk(ta, 64'(a_out[h*HW +: HW]), !ba_oe_n[h] ? 64'(m_ba[h]) : 64'd0);
      chk($sformatf("R6 half%0d b_oe", h), 64'(b_oe[h*HW +: HW]), ab_oe[h] ? 64'h3FFFF : 64'd0);
      chk($sformatf("R7 half%0d a_oe", h), 64'(a_oe[h*HW +: HW]), !ba_oe_n[h] ? 64'h3FFFF : 64'd0);
      chk($sformatf("R9 half%0d conflict", h), 64'(conflict[h]), 64'(ab_oe[h] && !ba_oe_n[h]));
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      a_in = rnd_word();
      b_in = rnd_word();
      cyc();
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ab_oe = '0; ab_le = '0; ab_ck = '0;
    ba_oe_n = '1; ba_le = '0; ba_ck = '0;
    a_in = '1; b_in = '1;
    for (int h = 0; h < H; h++) begin
      h_able[h] = '0; h_abck[h] = '0; h_bale[h] = '0; h_back[h] = '0;
      m_ab[h] = '0; m_ba[h] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R10 reset b_out", 64'(b_out), 64'd0);
    chk("R10 reset a_out", 64'(a_out), 64'd0);
    chk("R10 reset enables", 64'({a_oe, b_oe} != '0), 64'd0);
    chk("R10 reset conflict", 64'(conflict), 64'd0);
    // Check the stored zeros by enabling outputs while still in reset.
    ab_oe = '1; ba_oe_n = '0;
    #1;
    chk("R10 reset stored A-to-B", 64'(b_out), 64'd0);
    chk("R10 reset stored B-to-A", 64'(a_out), 64'd0);
    rst_n = 1'b1;

    run(4);                                  // R4: no load yet, data ignored
    ab_le[0] = 1'b1; ba_le[1] = 1'b1;        // R2 on one half only (R1)
    run(6);
    ab_le = '0; ba_le = '0;                  // R3: closing the latches
    run(6);
    ab_oe[1] = 1'b0;                         // R6: load while disabled
    for (int p = 0; p < 2; p++) begin
      ab_ck[1] = 1'b1; run(3);
      ab_ck[1] = 1'b0; run(3);
    end
    ab_oe[1] = 1'b1;
    run(2);
    ba_oe_n[0] = 1'b1;                       // R7: active-low enable
    for (int p = 0; p < 2; p++) begin
      ba_ck[0] = 1'b1; run(2);
      ba_ck[0] = 1'b0; run(2);
    end
    ba_oe_n[0] = 1'b0;
    run(2);
    ab_ck = '1; ba_ck = '1; ab_le = '1;      // strobe edge while transparent
    run(4);
    ab_le = '0; ab_ck = '0; ba_ck = '0;
    run(4);

    for (int i = 0; i < 1500; i++) begin
      for (int h = 0; h < H; h++) begin
        if ($urandom_range(3) == 0) ab_le[h]   = ~ab_le[h];
        if ($urandom_range(2) == 0) ab_ck[h]   = ~ab_ck[h];
        if ($urandom_range(3) == 0) ba_le[h]   = ~ba_le[h];
        if ($urandom_range(2) == 0) ba_ck[h]   = ~ba_ck[h];
        if ($urandom_range(7) == 0) ab_oe[h]   = ~ab_oe[h];
        if ($urandom_range(7) == 0) ba_oe_n[h] = ~ba_oe_n[h];
      end
      run(1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule